// File: doc/BRIEF.md
# Paged Configuration Register Bus Slave

This block is a slave-only I2C endpoint that gives an external controller access to a bank of 8-bit configuration registers. It watches already-filtered SCL and SDA lines, finds start and stop conditions, and takes a 7-bit device address with a direction bit. It answers its own address. A write then carries a register subaddress followed by data bytes. A read returns register contents from the current subaddress. The block acknowledges by pulling SDA low and drives SDA through an open-drain enable only.

Subaddresses are paged. A page register inside the block lives at subaddress FFH and selects which of the pages the lower subaddresses 00H to F7H refer to. Subaddresses F8H to FFH form a global window that is reached whatever page is active. The rest of the chip sees a synchronous register-file port with a write strobe, a read strobe, subaddress, page, global flag and write data. Read data returns on an input one cycle after the read strobe.

Top module: `paged_cfg_i2c`

## Requirements
- R1: Bus activity that does not follow a start condition (SDA falling while SCL is high) is ignored: no acknowledge and no register strobe.
- R2: After a start, a first byte whose upper seven bits equal DEV_ADDR is acknowledged with SDA held low through the ninth clock. Bit 0 of that byte selects the direction (0 write, 1 read). SDA changes only while SCL is low.
- R3: A first byte with a different address is not acknowledged, and all later bytes are ignored until the next start.
- R4: In a write, the byte after the address loads the subaddress. Each further byte gives one single-cycle write strobe carrying subaddress and data, after which the subaddress increments and wraps from FFH to 00H. Write and read strobes never coincide.
- R5: Subaddresses F8H to FEH are global: their strobes raise the global flag and reach the same register whatever page is active.
- R6: A write to FFH sets the active page if the value is below NUM_PAGES (12) and is otherwise dropped. A read of FFH returns the active page. FFH never appears on the register-file port.
- R7: Strobes for subaddresses 00H to F7H carry the active page on the page output.
- R8: In a read, the slave sends the register at the current subaddress MSB first. After each byte the master acknowledges, the subaddress increments and the next register is sent.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and stays released until the next start.
- R10: A repeated start restarts address reception and keeps the subaddress set by the previous write phase.
- R11: During and after reset, SDA is released, both strobes are low and the active page is 0.
- R12: A stop condition (SDA rising while SCL is high) returns the block to idle. Bytes sent after it without a new start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Filtered bus clock |
| sda_i | input | 1 | Filtered bus data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_wr_o | output | 1 | Register write strobe, one cycle |
| rf_rd_o | output | 1 | Register read strobe, one cycle |
| rf_addr_o | output | 8 | Subaddress of the strobe |
| rf_global_o | output | 1 | Strobe targets the global window |
| rf_page_o | output | PAGE_W (4) | Active page |
| rf_wdata_o | output | 8 | Write data |
| rf_rdata_i | input | 8 | Read data, valid the cycle after rf_rd_o |

## Verification
Two functions meet in one clock: the byte taken at FFH updates the page register, and the same edge advances the subaddress that the next data byte uses. A write burst starting at FEH crosses the global window into the page register and wraps to 00H, so the byte after the page change must already land in the new page. The result is judged at the port: the strobe for 00H must carry the new page. A bench-side register file, keyed by page and subaddress, is compared against a model. The same burst is also read back across the wrap, and randomized bursts that end near FFH repeat the case with legal and illegal page values.

// File: rtl/pgi_pkg.sv
// Shared types and constants for the paged configuration bus slave.
// Assumes 8-bit subaddresses with the global window at the top of the map.
package pgi_pkg;
    localparam logic [7:0] PGI_GLOBAL_BASE = 8'hF8;
    localparam logic [7:0] PGI_PAGE_SEL    = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } link_st_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_SUB,
        K_DATA
    } byte_kind_t;
endpackage

// File: rtl/pgi_bus_sense.sv
// Samples the filtered SCL/SDA lines into the clock domain and reports
// SCL edges plus start and stop conditions as one-cycle pulses.
// Assumes the inputs are glitch-free; SYNC_STAGES flops guard metastability.
module pgi_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_now_o
);
    logic [SYNC_STAGES:0] scl_q;
    logic [SYNC_STAGES:0] sda_q;
    logic scl_cur, scl_prev, sda_cur, sda_prev;

    // Shift both lines through the synchroniser chain; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-1:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_cur  = scl_q[SYNC_STAGES-1];
    assign scl_prev = scl_q[SYNC_STAGES];
    assign sda_cur  = sda_q[SYNC_STAGES-1];
    assign sda_prev = sda_q[SYNC_STAGES];

    // Derive edge and bus-condition pulses from current and previous samples.
    always_comb begin
        scl_rise_o = scl_cur & ~scl_prev;
        scl_fall_o = ~scl_cur & scl_prev;
        start_o    = scl_cur & scl_prev & sda_prev & ~sda_cur;
        stop_o     = scl_cur & scl_prev & ~sda_prev & sda_cur;
        sda_now_o  = sda_cur;
    end
endmodule

// File: rtl/pgi_link.sv
// Byte-level protocol engine: address match, acknowledge, receive and
// transmit shifting, master acknowledge handling. Issues one-cycle commands
// to the register map. Assumes SCL low phases span several clock cycles.
module pgi_link
    import pgi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h37
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       sda_now_i,
    input  logic [7:0] rbyte_i,
    output logic       sda_oe_o,
    output logic [7:0] byte_o,
    output logic       load_o,
    output logic       wr_o,
    output logic       adv_o,
    output logic       fetch_o
);
    link_st_t   st;
    byte_kind_t kind;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic       is_rd;
    logic       acked;
    logic       pend;

    assign byte_o = sh;

    // Protocol state machine; bus conditions take priority over bit traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= K_ADDR;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            is_rd    <= 1'b0;
            acked    <= 1'b0;
            pend     <= 1'b0;
            sda_oe_o <= 1'b0;
            load_o   <= 1'b0;
            wr_o     <= 1'b0;
            adv_o    <= 1'b0;
            fetch_o  <= 1'b0;
        end else begin
            load_o  <= 1'b0;
            wr_o    <= 1'b0;
            adv_o   <= 1'b0;
            fetch_o <= pend;
            pend    <= 1'b0;
            if (start_i) begin
                st       <= ST_RX;
                kind     <= K_ADDR;
                cnt      <= '0;
                is_rd    <= 1'b0;
                acked    <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (stop_i) begin
                st       <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise_i && cnt != 4'd8) begin
                            sh  <= {sh[6:0], sda_now_i};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall_i && cnt == 4'd8) begin
                            case (kind)
                                K_ADDR: begin
                                    if (sh[7:1] == DEV_ADDR) begin
                                        sda_oe_o <= 1'b1;
                                        st       <= ST_ACK;
                                        is_rd    <= sh[0];
                                        fetch_o  <= sh[0];
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                K_SUB: begin
                                    sda_oe_o <= 1'b1;
                                    st       <= ST_ACK;
                                    load_o   <= 1'b1;
                                end
                                default: begin
                                    sda_oe_o <= 1'b1;
                                    st       <= ST_ACK;
                                    wr_o     <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall_i) begin
                            cnt <= '0;
                            if (is_rd) begin
                                st       <= ST_TX;
                                tx       <= rbyte_i;
                                sda_oe_o <= ~rbyte_i[7];
                            end else begin
                                st       <= ST_RX;
                                sda_oe_o <= 1'b0;
                                kind     <= (kind == K_ADDR) ? K_SUB : K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall_i) begin
                            if (cnt == 4'd7) begin
                                sda_oe_o <= 1'b0;
                                st       <= ST_MACK;
                                acked    <= 1'b0;
                            end else begin
                                cnt      <= cnt + 4'd1;
                                tx       <= {tx[6:0], 1'b0};
                                sda_oe_o <= ~tx[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise_i) begin
                            if (!sda_now_i) begin
                                acked <= 1'b1;
                                adv_o <= 1'b1;
                                pend  <= 1'b1;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end else if (scl_fall_i && acked) begin
                            acked    <= 1'b0;
                            cnt      <= '0;
                            tx       <= rbyte_i;
                            sda_oe_o <= ~rbyte_i[7];
                            st       <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pgi_regmap.sv
// Subaddress pointer, page register and register-file strobe generation.
// FFH is held here; F8H-FEH are flagged global; lower subaddresses carry
// the active page. Assumes read data arrives the cycle after rf_rd_o.
module pgi_regmap
    import pgi_pkg::*;
#(
    parameter int NUM_PAGES = 12,
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        byte_i,
    input  logic              load_i,
    input  logic              wr_i,
    input  logic              adv_i,
    input  logic              fetch_i,
    input  logic [7:0]        rf_rdata_i,
    output logic              rf_wr_o,
    output logic              rf_rd_o,
    output logic [7:0]        rf_addr_o,
    output logic              rf_global_o,
    output logic [PAGE_W-1:0] rf_page_o,
    output logic [7:0]        rf_wdata_o,
    output logic [7:0]        rbyte_o
);
    localparam logic [7:0] PAGE_LIMIT = 8'(NUM_PAGES);

    logic [7:0]        ptr;
    logic [PAGE_W-1:0] page;
    logic              rd_q;

    assign rf_page_o = page;

    // Pointer, page update, strobe launch and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr         <= '0;
            page        <= '0;
            rd_q        <= 1'b0;
            rf_wr_o     <= 1'b0;
            rf_rd_o     <= 1'b0;
            rf_addr_o   <= '0;
            rf_global_o <= 1'b0;
            rf_wdata_o  <= '0;
            rbyte_o     <= '0;
        end else begin
            rf_wr_o <= 1'b0;
            rf_rd_o <= 1'b0;
            rd_q    <= rf_rd_o;
            if (load_i) begin
                ptr <= byte_i;
            end
            if (wr_i) begin
                if (ptr == PGI_PAGE_SEL) begin
                    if (byte_i < PAGE_LIMIT) begin
                        page <= byte_i[PAGE_W-1:0];
                    end
                end else begin
                    rf_wr_o     <= 1'b1;
                    rf_addr_o   <= ptr;
                    rf_wdata_o  <= byte_i;
                    rf_global_o <= (ptr >= PGI_GLOBAL_BASE);
                end
                ptr <= ptr + 8'd1;
            end
            if (adv_i) begin
                ptr <= ptr + 8'd1;
            end
            if (fetch_i) begin
                if (ptr == PGI_PAGE_SEL) begin
                    rbyte_o <= {{(8-PAGE_W){1'b0}}, page};
                end else begin
                    rf_rd_o     <= 1'b1;
                    rf_addr_o   <= ptr;
                    rf_global_o <= (ptr >= PGI_GLOBAL_BASE);
                end
            end
            if (rd_q) begin
                rbyte_o <= rf_rdata_i;
            end
        end
    end
endmodule

// File: rtl/paged_cfg_i2c.sv
// Top level of the paged configuration bus slave: line sensing, byte
// engine and register map. Assumes filtered SCL/SDA and an external
// open-drain pad driven by sda_oe_o.
module paged_cfg_i2c #(
    parameter logic [6:0] DEV_ADDR    = 7'h37,
    parameter int         NUM_PAGES   = 12,
    parameter int         SYNC_STAGES = 2,
    localparam int        PAGE_W      = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              rf_wr_o,
    output logic              rf_rd_o,
    output logic [7:0]        rf_addr_o,
    output logic              rf_global_o,
    output logic [PAGE_W-1:0] rf_page_o,
    output logic [7:0]        rf_wdata_o,
    input  logic [7:0]        rf_rdata_i
);
    logic       scl_rise, scl_fall, bus_start, bus_stop, sda_now;
    logic [7:0] rx_byte, rd_byte;
    logic       cmd_load, cmd_wr, cmd_adv, cmd_fetch;

    pgi_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop),
        .sda_now_o  (sda_now)
    );

    pgi_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .sda_now_i  (sda_now),
        .rbyte_i    (rd_byte),
        .sda_oe_o   (sda_oe_o),
        .byte_o     (rx_byte),
        .load_o     (cmd_load),
        .wr_o       (cmd_wr),
        .adv_o      (cmd_adv),
        .fetch_o    (cmd_fetch)
    );

    pgi_regmap #(.NUM_PAGES(NUM_PAGES)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_i      (rx_byte),
        .load_i      (cmd_load),
        .wr_i        (cmd_wr),
        .adv_i       (cmd_adv),
        .fetch_i     (cmd_fetch),
        .rf_rdata_i  (rf_rdata_i),
        .rf_wr_o     (rf_wr_o),
        .rf_rd_o     (rf_rd_o),
        .rf_addr_o   (rf_addr_o),
        .rf_global_o (rf_global_o),
        .rf_page_o   (rf_page_o),
        .rf_wdata_o  (rf_wdata_o),
        .rbyte_o     (rd_byte)
    );
endmodule

// File: rtl/pgi_checker.sv
// Protocol and port properties of the paged bus slave, bound to the top.
module pgi_checker #(
    parameter int NUM_PAGES = 12,
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic              rf_wr_o,
    input logic              rf_rd_o,
    input logic [7:0]        rf_addr_o,
    input logic [PAGE_W-1:0] rf_page_o
);
    // R2: the slave moves SDA only while SCL is low
    p_sda_move_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R4: write and read strobes never coincide
    p_wr_rd_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_o && rf_rd_o));

    // R4: a write strobe lasts one cycle
    p_wr_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_o |=> !rf_wr_o);

    // R6: the active page stays below the page count
    p_page_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rf_page_o} < (PAGE_W+1)'(NUM_PAGES));

    // R6: the page register never shows up on the register-file port
    p_sel_reg_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_o || rf_rd_o) |-> rf_addr_o != 8'hFF);
endmodule

bind paged_cfg_i2c pgi_checker #(.NUM_PAGES(NUM_PAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .rf_wr_o   (rf_wr_o),
    .rf_rd_o   (rf_rd_o),
    .rf_addr_o (rf_addr_o),
    .rf_page_o (rf_page_o)
);

// File: tb/paged_cfg_i2c_tb_top.sv
module paged_cfg_i2c_tb_top;
    localparam int         Q  = 8;
    localparam int         NP = 12;
    localparam logic [6:0] SA = 7'h37;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe, rf_wr, rf_rd, rf_glob;
    logic [7:0] rf_addr, rf_wd, rdata;
    logic [3:0] rf_page;
    wire  sda_line = ~(m_low | sda_oe);

    paged_cfg_i2c #(.DEV_ADDR(SA), .NUM_PAGES(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .rf_wr_o(rf_wr), .rf_rd_o(rf_rd),
        .rf_addr_o(rf_addr), .rf_global_o(rf_glob), .rf_page_o(rf_page),
        .rf_wdata_o(rf_wd), .rf_rdata_i(rdata)
    );

    // Bench register file behind the port, plus strobe observation
    logic [7:0] rfmem [0:4095];
    logic [7:0] rfg [0:7];
    int         wr_seen = 0;
    logic       last_glob = 1'b0;
    logic [3:0] last_page = '0;
    logic [7:0] last_addr = '0;
    always @(posedge clk) begin
        if (rf_wr) begin
            if (rf_glob) rfg[rf_addr[2:0]] <= rf_wd;
            else rfmem[{rf_page, rf_addr}] <= rf_wd;
            wr_seen   <= wr_seen + 1;
            last_glob <= rf_glob;
            last_page <= rf_page;
            last_addr <= rf_addr;
        end
        if (rf_rd) rdata <= rf_glob ? rfg[rf_addr[2:0]] : rfmem[{rf_page, rf_addr}];
    end

    // Expected model
    logic [7:0] em [0:4095];
    logic [7:0] eg [0:7];
    int         epage = 0;
    logic [7:0] wbuf [0:7];
    int total = 0, fails = 0, cyc = 0;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", total, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL R11 watchdog: actual %0d cycles, expected completion earlier", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mdl_read(input logic [7:0] a);
        if (a == 8'hFF) return 8'(epage);
        if (a >= 8'hF8) return eg[a[2:0]];
        return em[{epage[3:0], a}];
    endfunction

    task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'hFF) begin
            if (d < 8'(NP)) epage = int'(d);
        end else if (a >= 8'hF8) eg[a[2:0]] = d;
        else em[{epage[3:0], a}] = d;
    endtask

    task automatic bit_out(input logic v);
        m_low = !v; tick(Q); scl = 1'b1; tick(Q); tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl = 1'b0; tick(Q);
        end
        bit_out(!mack);
    endtask

    task automatic bstart();
        m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
    endtask

    task automatic do_write(input logic [7:0] sub, input int n);
        logic ack;
        logic [7:0] a;
        bstart();
        send_byte({SA, 1'b0}, ack); check(ack, "R2 address ack", ack, 1);
        send_byte(sub, ack);        check(ack, "R4 subaddress ack", ack, 1);
        a = sub;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); check(ack, "R4 data ack", ack, 1);
            mdl_write(a, wbuf[i]);
            a = a + 8'd1;
        end
        bstop();
    endtask

    task automatic do_read(input logic [7:0] sub, input int n, input string req);
        logic ack;
        logic [7:0] a, b;
        bstart();
        send_byte({SA, 1'b0}, ack); check(ack, "R2 address ack", ack, 1);
        send_byte(sub, ack);        check(ack, "R4 subaddress ack", ack, 1);
        bstart();
        send_byte({SA, 1'b1}, ack); check(ack, "R10 read address after repeated start", ack, 1);
        a = sub;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            check(b == mdl_read(a), req, b, mdl_read(a));
            a = a + 8'd1;
        end
        bstop();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        int w0, mism, n;
        logic [7:0] sub;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 4096; i++) begin rfmem[i] = 8'h00; em[i] = 8'h00; end
        for (int i = 0; i < 8; i++) begin rfg[i] = 8'h00; eg[i] = 8'h00; end
        rdata = 8'h00;

        // R11: reset state
        tick(5);
        check(!sda_oe && !rf_wr && !rf_rd, "R11 outputs in reset", {sda_oe, rf_wr, rf_rd}, 0);
        rst_n = 1'b1; tick(4);
        check(!sda_oe && rf_page == 4'd0, "R11 after reset", {sda_oe, rf_page}, 0);

        // R1: byte without a start
        scl = 1'b0; tick(Q);
        send_byte({SA, 1'b0}, ack);
        check(!ack, "R1 no ack without start", ack, 0);
        send_byte(8'h10, ack);
        check(!ack && wr_seen == 0, "R1 no strobe without start", wr_seen, 0);
        bstop();

        // R4/R7: plain write in page 0
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(8'h10, 3);
        check(wr_seen == 3, "R4 one strobe per data byte", wr_seen, 3);
        check(last_page == 4'd0 && last_addr == 8'h12, "R7 page 0 last write", {last_page, last_addr}, 12'h012);

        // R6: page select at FF, not on the port
        w0 = wr_seen;
        wbuf[0] = 8'h05; do_write(8'hFF, 1);
        check(wr_seen == w0, "R6 FF write hidden", wr_seen, w0);
        check(rf_page == 4'd5, "R6 page set", rf_page, 5);
        wbuf[0] = 8'h44; wbuf[1] = 8'h55; do_write(8'h10, 2);
        check(last_page == 4'd5, "R7 active page on strobe", last_page, 5);
        do_read(8'hFF, 1, "R6 page readback");
        wbuf[0] = 8'h0C; do_write(8'hFF, 1);
        check(rf_page == 4'd5, "R6 out-of-range page dropped", rf_page, 5);
        do_read(8'hFF, 1, "R6 page readback after drop");

        // R5: global window
        wbuf[0] = 8'h9A; do_write(8'hF9, 1);
        check(last_glob == 1'b1, "R5 global flag", last_glob, 1);
        wbuf[0] = 8'h02; do_write(8'hFF, 1);
        do_read(8'hF9, 1, "R5 global read from other page");
        do_read(8'h10, 1, "R7 lower address in new page");

        // R4/R6 same-cycle case: burst FE -> FF -> 00
        wbuf[0] = 8'hA5; wbuf[1] = 8'h07; wbuf[2] = 8'h3C;
        do_write(8'hFE, 3);
        check(last_page == 4'd7 && last_addr == 8'h00, "R4 wrap write lands in new page",
              {last_page, last_addr}, 12'h700);
        do_read(8'hFE, 3, "R8 burst read across wrap");

        // R8: multi-byte read from page 5 data
        wbuf[0] = 8'h05; do_write(8'hFF, 1);
        do_read(8'h10, 3, "R8 multi-byte read");

        // R9: master NACK releases the bus
        bstart();
        send_byte({SA, 1'b0}, ack); send_byte(8'h10, ack);
        bstart();
        send_byte({SA, 1'b1}, ack);
        recv_byte(b, 1'b0);
        check(b == mdl_read(8'h10), "R9 byte before nack", b, mdl_read(8'h10));
        recv_byte(b, 1'b0);
        check(b == 8'hFF, "R9 released after nack", b, 8'hFF);
        bstop();

        // R3: address mismatch
        w0 = wr_seen;
        bstart();
        send_byte({7'h12, 1'b0}, ack); check(!ack, "R3 mismatch not acked", ack, 0);
        send_byte(8'h20, ack);         check(!ack, "R3 later byte ignored", ack, 0);
        send_byte(8'h77, ack);
        bstop();
        check(wr_seen == w0, "R3 no strobe after mismatch", wr_seen, w0);

        // R12: bytes after stop without start
        scl = 1'b0; tick(Q);
        send_byte({SA, 1'b0}, ack); check(!ack, "R12 idle after stop", ack, 0);
        send_byte(8'h30, ack);
        bstop();
        check(wr_seen == w0, "R12 no strobe after stop", wr_seen, w0);

        // Random bursts, including ones that reach FFH
        for (int t = 0; t < 12; t++) begin
            wbuf[0] = 8'($urandom % NP); do_write(8'hFF, 1);
            sub = 8'($urandom % 256);
            if (t % 4 == 0) sub = 8'hFD;
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom % 256);
            do_write(sub, n);
            do_read(sub, n, "R8 random readback");
        end

        // R4: bench register file matches the model
        mism = 0;
        for (int i = 0; i < 4096; i++) if (rfmem[i] !== em[i]) mism++;
        for (int i = 0; i < 8; i++) if (rfg[i] !== eg[i]) mism++;
        check(mism == 0, "R4 register contents", mism, 0);

        summary();
        $finish;
    end
endmodule